// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt sources for a small processor core and hands the core one request at a time. The sources are a reset request, a non-maskable edge input, three external edge inputs whose active edge is selectable, and three on-chip peripheral requests (timer, serial port, end of message). Each source has a pending flag. A flag is set by the source's trigger whether or not the source is enabled. Enables are applied per source and through one global enable. When several sources are eligible at once, a fixed ranking picks the winner.

The block drives a 16-bit vector address for the winning source straight to the core. The core raises `instr_done` at an instruction boundary, and the block then asserts a one-cycle take pulse. The reset request is the exception: it is taken without waiting for a boundary. A small register port gives read and write access to the enable, pending and polarity registers. Pushing the return address and fetching from the vector table are left to the core.

Top module: `vic_core`

## Requirements
- R1: While `rst` is high, `irq_take` is low. On the first cycle after `rst` falls, the pending register (address 1) reads 8'h01, and the enable register (address 0) and polarity register (address 2) read 8'h00. In that same cycle `irq_take` is high with vector 16'hFFFE and no `instr_done` needed. After the next edge, pending bit 0 is clear.
- R2: Source ranks are: 0 reset, 1 non-maskable input, 2..4 external pins `ext_pin[0..2]`, 5 timer, 6 serial port, 7 end of message. Rank 0 has the highest priority. `irq_vector` is 16'hFFFE minus twice the rank of the lowest-ranked eligible source, and 16'h0000 when no source is eligible.
- R3: Ranks 0 and 1 are eligible whenever they are pending. A rank k of 2 to 7 is eligible only when enable bit k and enable bit 0 (global enable) are both 1. Enable bit 1 always reads 0.
- R4: A trigger sets pending bit k even when rank k is masked. Pending bit k for rank k reads back at address 1.
- R5: The non-maskable pin triggers on a rising edge only. Polarity bit j (address 2, bits 2:0) selects the edge for `ext_pin[j]`: 1 for rising, 0 for falling. The opposite edge is ignored. A pin change made between two clock edges appears in the pending register after the third following edge.
- R6: A rising edge on `tmr_req`, `uart_req` or `eom_req` sets its pending bit at the next clock edge.
- R7: A source of rank 1 to 7 is taken only in a cycle where `instr_done` is high. `irq_take` is high in exactly the cycles where `instr_done` is high and some source is eligible, plus the reset case of R1.
- R8: A take clears the winner's pending bit at the next edge if its rank is 0 to 4. Peripheral pending bits (ranks 5 to 7) stay set until software writes them.
- R9: A take clears the global enable at the next edge. A `reti` pulse without a take sets it. When both happen in the same cycle, the take wins.
- R10: A write to address 1 replaces the pending register. A hardware trigger arriving in the same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; release raises the reset request |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| tmr_req | input | 1 | Timer request, synchronous |
| uart_req | input | 1 | Serial port request, synchronous |
| eom_req | input | 1 | End-of-message request, synchronous |
| instr_done | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 pending, 2 polarity |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_take | output | 1 | One-cycle take-interrupt pulse |
| irq_vector | output | 16 | Vector address of the current winner |

## Verification
The results arrive at different times after a stimulus:
- **Vector, take and read data:** these are combinational. The bench samples them one time step after driving the inputs, within the same cycle.
- **Pending and enable updates:** a register write, a take or a `reti` shows up after exactly one clock edge. A peripheral request edge also sets its pending bit after one edge.
- **Pin edges:** a change on a pin is counted as due after the third edge. The bench checks that the bit is still clear after the second edge.

All inputs are driven one step after a rising edge, and every check is taken before the next edge.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC           = 8;
    localparam int RANK_W         = $clog2(NSRC);
    localparam int DATA_W         = 8;
    localparam int VEC_W          = 16;
    localparam int N_PIN          = 4;   // nmi plus three external pins
    localparam int N_PERIPH       = 3;
    localparam int N_EXT          = N_PIN - 1;
    localparam int FIRST_MASKABLE = 2;
    localparam int LAST_SELF_CLR  = 4;   // ranks 0..4 clear on take
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;

    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_PEND   = 2'd1,
        ADDR_POL    = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              valid;
        logic [RANK_W-1:0] rank;
    } win_t;

    function automatic logic [VEC_W-1:0] rank_vec(input logic [RANK_W-1:0] r);
        return VEC_TOP - {{(VEC_W-RANK_W-1){1'b0}}, r, 1'b0};
    endfunction

    function automatic logic [NSRC-1:0] self_clr_mask(input win_t w);
        logic [NSRC-1:0] m;
        m = '0;
        if (w.valid && (int'(w.rank) <= LAST_SELF_CLR))
            m[w.rank] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/vic_pin_edge.sv
module vic_pin_edge #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    localparam int MSB = STAGES - 1;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [STAGES-1:0] shreg;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '0;
                prev  <= 1'b0;
            end else begin
                shreg <= {shreg[STAGES-2:0], pin[i]};
                prev  <= shreg[MSB];
            end
        end

        assign hit[i] = rise_sel[i] ? (shreg[MSB] & ~prev) : (~shreg[MSB] & prev);
    end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] eligible,
    output win_t            win
);
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win.valid = 1'b1;
                win.rank  = RANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  reg_addr_e                    reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic [NSRC-1:0]              hw_set,
    input  logic                         take,
    input  logic [NSRC-1:0]              take_clr,
    input  logic                         reti,
    output logic                         gie,
    output logic [NSRC-1:FIRST_MASKABLE] en_hi,
    output logic [NSRC-1:0]              pend,
    output logic [N_EXT-1:0]             pol,
    output logic [DATA_W-1:0]            reg_rdata
);
    logic            wr_en, wr_pend, wr_pol;
    logic [NSRC-1:0] pend_base;

    assign wr_en   = reg_wr && (reg_addr == ADDR_ENABLE);
    assign wr_pend = reg_wr && (reg_addr == ADDR_PEND);
    assign wr_pol  = reg_wr && (reg_addr == ADDR_POL);

    // software write first, then the take clear, then hardware sets on top
    assign pend_base = wr_pend ? reg_wdata : pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= {{(NSRC-1){1'b0}}, 1'b1};
            gie   <= 1'b0;
            en_hi <= '0;
            pol   <= '0;
        end else begin
            pend <= (pend_base & ~take_clr) | hw_set;
            if (take)
                gie <= 1'b0;
            else if (reti)
                gie <= 1'b1;
            else if (wr_en)
                gie <= reg_wdata[0];
            if (wr_en)
                en_hi <= reg_wdata[NSRC-1:FIRST_MASKABLE];
            if (wr_pol)
                pol <= reg_wdata[N_EXT-1:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_ENABLE: reg_rdata = {en_hi, 1'b0, gie};
            ADDR_PEND:   reg_rdata = pend;
            ADDR_POL:    reg_rdata = {{(DATA_W-N_EXT){1'b0}}, pol};
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic              tmr_req,
    input  logic              uart_req,
    input  logic              eom_req,
    input  logic              instr_done,
    input  logic              reti,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_take,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [N_PIN-1:0]             pin_hit;
    logic [N_PERIPH-1:0]          per_req, per_prev, per_hit;
    logic [NSRC-1:0]              hw_set, pend, eligible, take_clr;
    logic [NSRC-1:FIRST_MASKABLE] en_hi;
    logic [N_EXT-1:0]             pol;
    logic                         gie;
    logic                         pend_wr;
    win_t                         win;

    vic_pin_edge #(.W(N_PIN), .STAGES(2)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .pin      ({ext_pin, nmi_pin}),
        .rise_sel ({pol, 1'b1}),
        .hit      (pin_hit)
    );

    assign per_req = {eom_req, uart_req, tmr_req};

    always_ff @(posedge clk) begin
        if (rst) per_prev <= '0;
        else     per_prev <= per_req;
    end

    assign per_hit = per_req & ~per_prev;
    assign hw_set  = {per_hit, pin_hit, 1'b0};

    for (genvar k = 0; k < NSRC; k++) begin : g_elig
        if (k < FIRST_MASKABLE) begin : g_nm
            assign eligible[k] = pend[k];
        end else begin : g_m
            assign eligible[k] = pend[k] & en_hi[k] & gie;
        end
    end

    vic_arbiter u_arb (
        .eligible (eligible),
        .win      (win)
    );

    assign irq_take   = !rst && win.valid && (instr_done || (win.rank == '0));
    assign irq_vector = win.valid ? rank_vec(win.rank) : '0;
    assign take_clr   = irq_take ? self_clr_mask(win) : '0;
    assign pend_wr    = reg_wr && (reg_addr == ADDR_PEND);

    vic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr_e'(reg_addr)),
        .reg_wdata (reg_wdata),
        .hw_set    (hw_set),
        .take      (irq_take),
        .take_clr  (take_clr),
        .reti      (reti),
        .gie       (gie),
        .en_hi     (en_hi),
        .pend      (pend),
        .pol       (pol),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/vic_chk.sv
module vic_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq_take,
    input logic [15:0] irq_vector,
    input logic        instr_done,
    input logic        reti,
    input logic        gie,
    input logic [7:5]  per_pend,
    input logic        pend_wr
);
    // R7
    boundary_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take && !instr_done |-> irq_vector == 16'hFFFE);

    // R7
    take_has_vec_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> irq_vector != 16'h0000);

    // R2
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_vector == 16'h0000 || (irq_vector[0] == 1'b0 && irq_vector >= 16'hFFF0));

    // R9
    gie_drop_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !gie);

    // R9
    gie_set_chk: assert property (@(posedge clk) disable iff (rst)
        reti && !irq_take |=> gie);

    for (genvar k = 5; k < 8; k++) begin : g_hold
        // R8
        periph_hold_chk: assert property (@(posedge clk) disable iff (rst)
            per_pend[k] && !pend_wr |=> per_pend[k]);
    end

endmodule

bind vic_core vic_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_take   (irq_take),
    .irq_vector (irq_vector),
    .instr_done (instr_done),
    .reti       (reti),
    .gie        (gie),
    .per_pend   (pend[7:5]),
    .pend_wr    (pend_wr)
);

// File: tb/sim_vic_core.sv
`timescale 1ns/1ps
module sim_vic_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 1'b0;
    logic [2:0]  ext_pin = 3'b000;
    logic        tmr_req = 1'b0, uart_req = 1'b0, eom_req = 1'b0;
    logic        instr_done = 1'b0, reti = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_take;
    logic [15:0] irq_vector;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vic_core u0 (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .ext_pin(ext_pin),
        .tmr_req(tmr_req), .uart_req(uart_req), .eom_req(eom_req),
        .instr_done(instr_done), .reti(reti), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_take(irq_take), .irq_vector(irq_vector)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int exp_rank(input logic [7:0] p, input logic [7:0] e);
        for (int r = 0; r < 8; r++)
            if (p[r] && (r < 2 || (e[r] && e[0]))) return r;
        return -1;
    endfunction

    function automatic logic [15:0] exp_vec(input logic [7:0] p, input logic [7:0] e);
        int r;
        r = exp_rank(p, e);
        return (r < 0) ? 16'h0000 : 16'hFFFE - 16'(2 * r);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, en, pd, ep;
        int         r;
        void'($urandom(32'd4242));
        repeat (3) tick();
        chk("R1 take held in reset", {15'h0, irq_take}, 16'h0);
        rst = 1'b0;
        #1;
        chk("R1 reset take", {15'h0, irq_take}, 16'h1);
        chk("R1 reset vector", irq_vector, 16'hFFFE);
        rd(2'd1, d); chk("R1 pending after reset", {8'h0, d}, 16'h01);
        rd(2'd0, d); chk("R1 enable after reset", {8'h0, d}, 16'h00);
        rd(2'd2, d); chk("R1 polarity after reset", {8'h0, d}, 16'h00);
        tick();
        rd(2'd1, d); chk("R1 reset pending cleared", {8'h0, d}, 16'h00);
        chk("R1 take ends", {15'h0, irq_take}, 16'h0);

        // non-maskable rising edge, three edges of latency
        nmi_pin = 1'b1;
        tick(); tick();
        rd(2'd1, d); chk("R5 nmi not yet pending", {8'h0, d}, 16'h00);
        tick();
        rd(2'd1, d); chk("R5 nmi pending", {8'h0, d}, 16'h02);
        chk("R3 nmi ignores enables", irq_vector, 16'hFFFC);
        chk("R7 no take without boundary", {15'h0, irq_take}, 16'h0);
        instr_done = 1'b1; #1;
        chk("R7 take at boundary", {15'h0, irq_take}, 16'h1);
        tick(); instr_done = 1'b0; #1;
        rd(2'd1, d); chk("R8 nmi pending cleared by take", {8'h0, d}, 16'h00);
        chk("R7 take one cycle", {15'h0, irq_take}, 16'h0);
        nmi_pin = 1'b0;
        repeat (3) tick();
        rd(2'd1, d); chk("R5 nmi falling ignored", {8'h0, d}, 16'h00);

        // external pin 0, default polarity falling
        ext_pin[0] = 1'b1;
        repeat (3) tick();
        rd(2'd1, d); chk("R5 rising ignored at falling polarity", {8'h0, d}, 16'h00);
        ext_pin[0] = 1'b0;
        repeat (3) tick();
        rd(2'd1, d); chk("R4 masked source still pending", {8'h0, d}, 16'h04);
        chk("R3 masked gives no vector", irq_vector, 16'h0000);
        wr(2'd0, 8'h04);
        chk("R3 own enable without global", irq_vector, 16'h0000);
        wr(2'd0, 8'h05);
        chk("R2 ext0 vector", irq_vector, 16'hFFFA);
        instr_done = 1'b1; #1;
        chk("R7 ext take", {15'h0, irq_take}, 16'h1);
        tick(); instr_done = 1'b0;
        rd(2'd1, d); chk("R8 ext pending cleared", {8'h0, d}, 16'h00);
        rd(2'd0, d); chk("R9 take clears global enable", {8'h0, d}, 16'h04);

        // polarity rising on ext pin 1
        wr(2'd2, 8'h02);
        ext_pin[1] = 1'b1;
        repeat (3) tick();
        rd(2'd1, d); chk("R5 rising polarity on ext1", {8'h0, d}, 16'h08);
        wr(2'd1, 8'h00);
        ext_pin[1] = 1'b0;
        repeat (3) tick();
        rd(2'd1, d); chk("R5 falling ignored at rising polarity", {8'h0, d}, 16'h00);

        // peripheral request, software-cleared
        tmr_req = 1'b1;
        tick();
        rd(2'd1, d); chk("R6 timer pending", {8'h0, d}, 16'h20);
        wr(2'd0, 8'h21);
        chk("R2 timer vector", irq_vector, 16'hFFF4);
        instr_done = 1'b1; #1;
        chk("R7 timer take", {15'h0, irq_take}, 16'h1);
        tick(); instr_done = 1'b0;
        rd(2'd1, d); chk("R8 timer pending kept", {8'h0, d}, 16'h20);
        rd(2'd0, d); chk("R9 global enable cleared", {8'h0, d}, 16'h20);
        reti = 1'b1; tick(); reti = 1'b0;
        rd(2'd0, d); chk("R9 reti sets global enable", {8'h0, d}, 16'h21);
        tmr_req = 1'b0;

        // take and reti in the same cycle
        wr(2'd1, 8'h20);
        instr_done = 1'b1; reti = 1'b1; #1;
        chk("R9 take with reti", {15'h0, irq_take}, 16'h1);
        tick(); instr_done = 1'b0; reti = 1'b0;
        rd(2'd0, d); chk("R9 take wins over reti", {8'h0, d}, 16'h20);

        // hardware set beats software write
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00; uart_req = 1'b1;
        tick();
        reg_wr = 1'b0;
        rd(2'd1, d); chk("R10 set wins over write", {8'h0, d}, 16'h40);
        uart_req = 1'b0;
        wr(2'd1, 8'h00);

        // random enable and pending patterns
        for (int it = 0; it < 60; it++) begin
            en = 8'($urandom) & 8'hFD;
            pd = 8'($urandom) & 8'hFE;
            wr(2'd0, en);
            wr(2'd1, pd);
            rd(2'd1, d); chk("R10 pending write readback", {8'h0, d}, {8'h0, pd});
            chk("R2 random vector", irq_vector, exp_vec(pd, en));
            r = exp_rank(pd, en);
            instr_done = 1'b1; #1;
            chk("R7 random take", {15'h0, irq_take}, {15'h0, r >= 0});
            tick(); instr_done = 1'b0;
            ep = pd;
            if (r >= 0 && r <= 4) ep[r] = 1'b0;
            rd(2'd1, d); chk("R8 random pending after take", {8'h0, d}, {8'h0, ep});
            rd(2'd0, d); chk("R9 random global enable", {15'h0, d[0]}, {15'h0, en[0] && r < 0});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule